// File: doc/BRIEF.md
# Prescaled Countdown Interval Timer

This block counts a 12-bit value down to zero at a rate set by a 3-bit prescale select. When the count expires, it raises a one-cycle interrupt toward a processor. Software loads a reload value, picks the prescale, picks the mode and pulses start. In single-shot mode the timer expires once and then halts at zero until software starts it again. In continuous mode every expiry reloads the programmed value and counting carries on, so interrupts arrive at a fixed interval. A typical use is scheduling slow housekeeping work, such as polling a sensor, outside the main processing path.

The prescale select p divides the clock by 2 to the power p. The counter moves once per prescaled tick. A reload value of zero stands for the full 4096-tick span. All outputs are registered.

Top module: `ivl_timer`

## Requirements
- R1: After reset, count_o is 0, running_o is 0 and irq_o is 0.
- R2: A cycle with start_i high loads reload_i into count_o at the next edge, sets running_o and restarts the prescaler from zero. Start takes priority over stop_i in the same cycle.
- R3: With psel_i = p (0 to 7), a running counter moves once every 2^p clock cycles. The first move lands 2^p cycles after the start edge.
- R4: irq_o is high for exactly one cycle per expiry. That cycle is the first one in which count_o shows the value that follows the tick that took the count from 1 to zero.
- R5: In single-shot mode, an expiry leaves count_o at 0 and running_o low. Both stay that way until the next start.
- R6: In continuous mode, an expiry loads the reload_i value present at that tick and keeps running_o high. Interrupts then repeat every reload × 2^p cycles.
- R7: A cycle with stop_i high, and start_i low, clears running_o and leaves count_o unchanged. No interrupt follows until a new start.
- R8: A reload value of 0 gives 4096 ticks per expiry. The first tick shows count_o = 4095.
- R9: cont_i = 1 selects continuous mode and cont_i = 0 selects single-shot mode. The mode is sampled on the expiring tick itself.
- R10: While running_o is low and start_i is low, count_o holds and irq_o stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reload_i | input | 12 | Timeout value in ticks (0 means 4096) |
| psel_i | input | 3 | Prescale select, divide by 2^psel_i |
| cont_i | input | 1 | 1 = continuous, 0 = single-shot |
| start_i | input | 1 | Load reload value and run |
| stop_i | input | 1 | Halt counting, keep count |
| count_o | output | 12 | Current count |
| running_o | output | 1 | Timer is counting |
| irq_o | output | 1 | One-cycle expiry pulse |

## Verification
The hardest case to reach is an expiry whose handling depends on inputs that change while the timer runs. One example is a continuous run where the reload value is altered between expiries and the mode is then switched to single-shot just before a later expiry. The bench starts a continuous run with a small prescale. It rewrites reload_i on the clock after the first interrupt, then clears cont_i after the second interrupt. It then checks each later expiry at its computed cycle. The 4096-tick span of a zero reload is reached by running through one full wrap at the fastest prescale.

// File: rtl/ivl_timer_pkg.sv
`timescale 1ns/1ps
package ivl_timer_pkg;

    typedef enum logic {
        MODE_ONESHOT = 1'b0,
        MODE_CONT    = 1'b1
    } tmr_mode_e;

    localparam int unsigned TMR_CNT_W  = 12;
    localparam int unsigned TMR_PSEL_W = 3;

endpackage

// File: rtl/ivl_presc.sv
`timescale 1ns/1ps
module ivl_presc #(
    parameter int unsigned SEL_W = 3
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             clr_i,
    input  logic             en_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             tick_o
);
    // widest divide is 2^(2^SEL_W - 1), so that many accumulator bits
    localparam int unsigned DIV_W = (1 << SEL_W) - 1;

    typedef struct packed {
        logic [DIV_W-1:0] acc;
    } presc_t;

    presc_t            st_d, st_q;
    logic [DIV_W-1:0]  mask;

    assign mask   = ~({DIV_W{1'b1}} << sel_i);
    assign tick_o = en_i && ((st_q.acc & mask) == mask);

    always_comb begin
        st_d = st_q;
        if (clr_i) begin
            st_d.acc = '0;
        end else if (en_i) begin
            st_d.acc = st_q.acc + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/ivl_ctrl.sv
`timescale 1ns/1ps
module ivl_ctrl
    import ivl_timer_pkg::*;
#(
    parameter int unsigned CNT_W = 12
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [CNT_W-1:0] reload_i,
    input  logic             cont_i,
    input  logic             start_i,
    input  logic             stop_i,
    input  logic             tick_i,
    output logic             presc_clr_o,
    output logic             presc_en_o,
    output logic [CNT_W-1:0] count_o,
    output logic             running_o,
    output logic             irq_o
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             run;
        logic             irq;
    } ctrl_t;

    ctrl_t     st_d, st_q;
    tmr_mode_e mode;

    assign mode        = tmr_mode_e'(cont_i);
    assign presc_clr_o = start_i;
    assign presc_en_o  = st_q.run;

    always_comb begin
        st_d     = st_q;
        st_d.irq = 1'b0;
        if (start_i) begin
            st_d.cnt = reload_i;
            st_d.run = 1'b1;
        end else if (stop_i) begin
            st_d.run = 1'b0;
        end else if (st_q.run && tick_i) begin
            if (st_q.cnt == LAST) begin
                st_d.irq = 1'b1;
                if (mode == MODE_CONT) begin
                    st_d.cnt = reload_i;
                end else begin
                    st_d.cnt = '0;
                    st_d.run = 1'b0;
                end
            end else begin
                // zero wraps to all ones: a zero reload spans the full range
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count_o   = st_q.cnt;
    assign running_o = st_q.run;
    assign irq_o     = st_q.irq;

endmodule

// File: rtl/ivl_timer.sv
`timescale 1ns/1ps
module ivl_timer #(
    parameter int unsigned CNT_W  = ivl_timer_pkg::TMR_CNT_W,
    parameter int unsigned PSEL_W = ivl_timer_pkg::TMR_PSEL_W
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [CNT_W-1:0]  reload_i,
    input  logic [PSEL_W-1:0] psel_i,
    input  logic              cont_i,
    input  logic              start_i,
    input  logic              stop_i,
    output logic [CNT_W-1:0]  count_o,
    output logic              running_o,
    output logic              irq_o
);
    logic tick;
    logic presc_clr;
    logic presc_en;

    ivl_presc #(.SEL_W(PSEL_W)) presc_i (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .clr_i  (presc_clr),
        .en_i   (presc_en),
        .sel_i  (psel_i),
        .tick_o (tick)
    );

    ivl_ctrl #(.CNT_W(CNT_W)) ctrl_i (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .reload_i    (reload_i),
        .cont_i      (cont_i),
        .start_i     (start_i),
        .stop_i      (stop_i),
        .tick_i      (tick),
        .presc_clr_o (presc_clr),
        .presc_en_o  (presc_en),
        .count_o     (count_o),
        .running_o   (running_o),
        .irq_o       (irq_o)
    );

endmodule

// File: rtl/ivl_timer_chk.sv
`timescale 1ns/1ps
module ivl_timer_chk #(
    parameter int unsigned CNT_W  = 12,
    parameter int unsigned PSEL_W = 3
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic [CNT_W-1:0]  reload_i,
    input logic [PSEL_W-1:0] psel_i,
    input logic              cont_i,
    input logic              start_i,
    input logic              stop_i,
    input logic [CNT_W-1:0]  count_o,
    input logic              running_o,
    input logic              irq_o
);
    logic [PSEL_W-1:0] psel_unused;
    assign psel_unused = psel_i;

    assert_start_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        start_i |=> running_o && !irq_o && count_o == $past(reload_i));

    assert_oneshot_halt_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o && !$past(cont_i) |-> !running_o && count_o == '0);

    assert_cont_reload_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o && $past(cont_i) |-> running_o && count_o == $past(reload_i));

    assert_stop_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        stop_i && !start_i |=> !running_o && !irq_o && $stable(count_o));

    assert_idle_still_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !running_o && !start_i |=> !irq_o && $stable(count_o));

    assert_step_one_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        running_o && !start_i && !stop_i && count_o > CNT_W'(1)
        |=> count_o == $past(count_o) || count_o == $past(count_o) - 1'b1);

    assert_irq_needs_run_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |-> $past(running_o) && $past(count_o) == CNT_W'(1));

endmodule

bind ivl_timer ivl_timer_chk #(.CNT_W(CNT_W), .PSEL_W(PSEL_W)) chk_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .reload_i  (reload_i),
    .psel_i    (psel_i),
    .cont_i    (cont_i),
    .start_i   (start_i),
    .stop_i    (stop_i),
    .count_o   (count_o),
    .running_o (running_o),
    .irq_o     (irq_o)
);

// File: tb/ivl_timer_tb_top.sv
`timescale 1ns/1ps
module ivl_timer_tb_top;

    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic [11:0] reload_i = '0;
    logic [2:0]  psel_i = '0;
    logic        cont_i = 1'b0;
    logic        start_i = 1'b0;
    logic        stop_i = 1'b0;
    logic [11:0] count_o;
    logic        running_o;
    logic        irq_o;

    int checks = 0;
    int bad = 0;

    always #4 clk_i = ~clk_i;

    ivl_timer dut_i (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .reload_i  (reload_i),
        .psel_i    (psel_i),
        .cont_i    (cont_i),
        .start_i   (start_i),
        .stop_i    (stop_i),
        .count_o   (count_o),
        .running_o (running_o),
        .irq_o     (irq_o)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk_i);
    endtask

    // returns on the negedge just after the start edge
    task automatic kick(input logic [11:0] n, input logic [2:0] p, input logic c);
        @(negedge clk_i);
        reload_i = n;
        psel_i   = p;
        cont_i   = c;
        start_i  = 1'b1;
        @(negedge clk_i);
        start_i  = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1", "count after reset", count_o, 0);
        chk("R1", "running after reset", running_o, 0);
        chk("R1", "irq after reset", irq_o, 0);
    endtask

    task automatic t_oneshot();
        kick(12'd5, 3'd0, 1'b0);
        chk("R2", "count loaded", count_o, 5);
        chk("R2", "running set", running_o, 1);
        cyc(4);
        chk("R4", "no irq before expiry", irq_o, 0);
        chk("R3", "count before expiry", count_o, 1);
        cyc(1);
        chk("R4", "irq at expiry", irq_o, 1);
        chk("R5", "count zero at expiry", count_o, 0);
        chk("R5", "halted at expiry", running_o, 0);
        cyc(1);
        chk("R4", "irq one cycle", irq_o, 0);
        for (int i = 0; i < 20; i++) begin
            cyc(1);
            if (irq_o || count_o != 0 || running_o) begin
                chk("R10", "idle after single shot", {irq_o, running_o, count_o}, 0);
            end
        end
        chk("R5", "still zero later", count_o, 0);
    endtask

    task automatic t_prescale();
        kick(12'd4, 3'd3, 1'b0);
        cyc(7);
        chk("R3", "p=3 count before first tick", count_o, 4);
        cyc(1);
        chk("R3", "p=3 first tick", count_o, 3);
        cyc(23);
        chk("R3", "p=3 no irq at 31", irq_o, 0);
        cyc(1);
        chk("R3", "p=3 irq at 32", irq_o, 1);
        kick(12'd2, 3'd7, 1'b0);
        cyc(255);
        chk("R3", "p=7 no irq at 255", irq_o, 0);
        chk("R3", "p=7 count at 255", count_o, 1);
        cyc(1);
        chk("R3", "p=7 irq at 256", irq_o, 1);
    endtask

    task automatic t_cont();
        kick(12'd3, 3'd1, 1'b1);
        cyc(5);
        chk("R6", "no irq at 5", irq_o, 0);
        cyc(1);
        chk("R6", "irq at 6", irq_o, 1);
        chk("R6", "reloaded to 3", count_o, 3);
        chk("R9", "continuous keeps running", running_o, 1);
        reload_i = 12'd2;
        cyc(6);
        chk("R6", "irq at 12", irq_o, 1);
        chk("R6", "new reload 2", count_o, 2);
        cont_i = 1'b0;
        cyc(1);
        chk("R4", "irq drops at 13", irq_o, 0);
        cyc(3);
        chk("R9", "irq at 16", irq_o, 1);
        chk("R9", "single shot after mode change", running_o, 0);
        chk("R9", "count zero after mode change", count_o, 0);
    endtask

    task automatic t_stop();
        kick(12'd10, 3'd0, 1'b0);
        cyc(4);
        chk("R7", "count before stop", count_o, 6);
        stop_i = 1'b1;
        cyc(1);
        stop_i = 1'b0;
        chk("R7", "stopped", running_o, 0);
        chk("R7", "count held", count_o, 6);
        for (int i = 0; i < 10; i++) begin
            cyc(1);
            if (irq_o || count_o != 6) begin
                chk("R7", "hold while stopped", {irq_o, count_o}, 6);
            end
        end
        chk("R10", "count still held", count_o, 6);
        @(negedge clk_i);
        reload_i = 12'd9;
        start_i  = 1'b1;
        stop_i   = 1'b1;
        @(negedge clk_i);
        start_i  = 1'b0;
        stop_i   = 1'b0;
        chk("R2", "start beats stop running", running_o, 1);
        chk("R2", "start beats stop count", count_o, 9);
        cyc(1);
        chk("R2", "counting after restart", count_o, 8);
    endtask

    task automatic t_zero();
        kick(12'd0, 3'd0, 1'b1);
        cyc(1);
        chk("R8", "first tick wraps", count_o, 4095);
        cyc(4094);
        chk("R8", "no irq at 4095", irq_o, 0);
        cyc(1);
        chk("R8", "irq at 4096", irq_o, 1);
        chk("R8", "reload zero kept", count_o, 0);
        chk("R8", "still running", running_o, 1);
    endtask

    initial begin
        cyc(3);
        t_reset();
        rst_ni = 1'b1;
        cyc(2);
        t_oneshot();
        t_prescale();
        t_cont();
        t_stop();
        t_zero();
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk_i);
        checks++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

endmodule